// File: doc/BRIEF.md
# Memory Card Identification Controller

This block is the card-side controller that carries a memory card through bus identification. It takes commands that have already been decoded: a strobe, a 6-bit index, a 32-bit argument and a flag that marks an application-specific command. It answers with a response request (a kind code and a payload) and reports its current state. It holds a fixed 128-bit card identifier, an operating-conditions word with a supply-voltage window, and a 16-bit relative card address (RCA). Each new RCA is drawn from a deterministic pseudo-random sequence.

A host brings the card up in a fixed order. It first sends an application prefix and then an operating-conditions query, and repeats that pair until the card reports it is no longer busy. It then asks for the identifier and asks for an address. Once the card reaches stand-by, the host may ask for a new address as often as it likes, and the latest one replaces the previous one. If the host requests a voltage window that does not overlap the card's window, the card goes permanently inactive. CRC, serial framing on the command line and data transfers are handled by other blocks.

Top module: `card_ident_ctrl`

## Requirements
- R1: After reset, `card_state` is Idle (code 0), `rsp_valid` is low and `rca_out` is 0x0000. The state codes are: Idle 0, Ready 1, Identification 2, Stand-by 3, Inactive 7.
- R2: A prefix command (index 55, `cmd_app` low) is accepted when `cmd_arg[31:16]` equals the expected address. That address is `rca_out` in Stand-by and 0x0000 in Idle, Ready and Identification. On acceptance the block replies with kind 0 (acknowledge) and `rsp_data[2:0]` set to the current state code. The armed prefix applies only to the very next strobed command, whatever that command is.
- R3: An operating-conditions query (index 41 with `cmd_app` high) is acted on only when the prefix is armed and the state is Idle. In every other case it gets no response and causes no change.
- R4: If `cmd_arg[23:0]` overlaps `OCR_WINDOW`, the block replies with kind 1 and `rsp_data[31:0]` = {ready, 7'b0, `OCR_WINDOW`}. The ready bit is 1 only once `PWRUP_CYCLES` clocks have passed since reset; the card then moves to Ready. While the ready bit is 0, the card stays in Idle.
- R5: If `cmd_arg[23:0]` does not overlap `OCR_WINDOW`, the card gives no response and moves to Inactive. From then on, every command is ignored until reset.
- R6: The identifier request (index 55 excluded; index 2, `cmd_app` low) is answered only in Ready. The reply has kind 2 with `rsp_data` = `CID_VALUE`, and the state moves to Identification.
- R7: The address request (index 3, `cmd_app` low) is answered in Identification and in Stand-by. The reply has kind 3 with `rsp_data[31:16]` = the new RCA and `rsp_data[15:0]` = 0. The state becomes Stand-by, and `rca_out` shows the most recently published address.
- R8: Each new RCA is prev*`RCA_MUL` + `RCA_INC` (mod 2^16), where prev is the previous generator value and the first prev is `RCA_SEED`. A result of 0x0000 is never published: when it appears, the generator steps once more.
- R9: A command that is not valid in the current state gets no response, and it changes neither the state nor `rca_out`.
- R10: `rsp_valid` is a one-cycle pulse. It is high in the cycle after the edge that samples the strobe, and it is never high unless a strobe was sampled on the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle strobe for a decoded command |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| cmd_app | input | 1 | Marks the command as application-specific |
| rsp_valid | output | 1 | Response request pulse |
| rsp_kind | output | 2 | 0 acknowledge, 1 operating conditions, 2 identifier, 3 address |
| rsp_data | output | 128 | Response payload, right-aligned for short kinds |
| card_state | output | 3 | Current state code |
| rca_out | output | 16 | Most recently published relative address |

## Verification
A wrong internal state shows on `card_state` one cycle after the strobe that caused it. It also shows at the next identifier or address request, which is either answered when it should not be or silent when it should be answered. A prefix latch that is stuck armed or stuck clear shows on the second command after the prefix: an operating-conditions query is then acted on or dropped wrongly. A fault in the generator shows in the payload of the very next address reply. A fault in the power-up timing shows in the ready bit of the first query made after the power-up window closes.

// File: rtl/card_ident_pkg.sv
package card_ident_pkg;

  typedef enum logic [2:0] {
    CS_IDLE     = 3'd0,
    CS_READY    = 3'd1,
    CS_IDENT    = 3'd2,
    CS_STBY     = 3'd3,
    CS_INACTIVE = 3'd7
  } card_state_e;

  typedef enum logic [1:0] {
    RK_ACK   = 2'd0,
    RK_OCR   = 2'd1,
    RK_IDENT = 2'd2,
    RK_ADDR  = 2'd3
  } rsp_kind_e;

  localparam logic [5:0] IDX_PREFIX = 6'd55;
  localparam logic [5:0] IDX_OPCOND = 6'd41;
  localparam logic [5:0] IDX_IDENT  = 6'd2;
  localparam logic [5:0] IDX_ADDR   = 6'd3;

  // one step of the address sequence (mod 2^16)
  function automatic logic [15:0] rca_step(input logic [15:0] x,
                                           input logic [15:0] mul,
                                           input logic [15:0] inc);
    logic [15:0] prod;
    prod = x * mul;
    return prod + inc;
  endfunction

  // step, stepping again over the reserved zero address
  function automatic logic [15:0] rca_next(input logic [15:0] x,
                                           input logic [15:0] mul,
                                           input logic [15:0] inc);
    logic [15:0] cand;
    cand = rca_step(x, mul, inc);
    if (cand == 16'h0000) cand = rca_step(cand, mul, inc);
    return cand;
  endfunction

  function automatic logic [31:0] ocr_word(input logic        ready,
                                           input logic [23:0] window);
    return {ready, 7'b0, window};
  endfunction

  function automatic logic window_fits(input logic [23:0] asked,
                                       input logic [23:0] window);
    return (asked & window) != 24'h0;
  endfunction

endpackage

// File: rtl/card_ident_prefix.sv
// One-shot latch for the application prefix: any strobe consumes it.
module card_ident_prefix (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic arm,
  output logic armed
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      armed_q <= 1'b0;
    else if (strobe) armed_q <= arm;
  end

  assign armed = armed_q;
endmodule

// File: rtl/card_ident_pwrup.sv
// Power-up busy window counted from reset.
module card_ident_pwrup #(
  parameter int unsigned PWRUP_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic busy
);
  localparam int unsigned CW = $clog2(PWRUP_CYCLES + 2);
  localparam logic [CW-1:0] LIMIT = CW'(PWRUP_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (cnt_q < LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign busy = (cnt_q < LIMIT);
endmodule

// File: rtl/card_ident_rca_gen.sv
// Relative address generator and the published address register.
module card_ident_rca_gen
  import card_ident_pkg::*;
#(
  parameter logic [15:0] RCA_SEED = 16'h0001,
  parameter logic [15:0] RCA_MUL  = 16'h0005,
  parameter logic [15:0] RCA_INC  = 16'hFFFB
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        publish,
  output logic [15:0] rca_new,
  output logic [15:0] rca_cur
);
  logic [15:0] gen_q;
  logic [15:0] rca_q;

  assign rca_new = rca_next(gen_q, RCA_MUL, RCA_INC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_q <= RCA_SEED;
      rca_q <= 16'h0000;
    end else if (publish) begin
      gen_q <= rca_new;
      rca_q <= rca_new;
    end
  end

  assign rca_cur = rca_q;
endmodule

// File: rtl/card_ident_ctrl.sv
module card_ident_ctrl
  import card_ident_pkg::*;
#(
  parameter logic [127:0] CID_VALUE    = 128'h0312_5A3C_9E71_0B44_2D68_F0C1_5577_A9E3,
  parameter logic [23:0]  OCR_WINDOW   = 24'hFF8000,
  parameter int unsigned  PWRUP_CYCLES = 64,
  parameter logic [15:0]  RCA_SEED     = 16'h0001,
  parameter logic [15:0]  RCA_MUL      = 16'h0005,
  parameter logic [15:0]  RCA_INC      = 16'hFFFB
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  input  logic [5:0]   cmd_index,
  input  logic [31:0]  cmd_arg,
  input  logic         cmd_app,
  output logic         rsp_valid,
  output logic [1:0]   rsp_kind,
  output logic [127:0] rsp_data,
  output logic [2:0]   card_state,
  output logic [15:0]  rca_out
);

  card_state_e state_q, state_d;
  rsp_kind_e   kind_q, kind_d;
  logic [127:0] data_q, data_d;
  logic         valid_q;

  logic         prefix_armed;
  logic         pwr_busy;
  logic [15:0]  rca_new;
  logic [15:0]  rca_cur;

  // named events, also watched by the checker
  logic         plain_cmd, app_cmd, alive;
  logic [15:0]  prefix_addr;
  logic         ev_prefix_ok;
  logic         ev_opcond;
  logic         ev_opcond_ok;
  logic         ev_opcond_bad;
  logic         ev_cid;
  logic         ev_rca;
  logic         ev_answer;
  logic         ev_invalid;

  card_ident_prefix u_prefix (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (cmd_valid),
    .arm    (ev_prefix_ok),
    .armed  (prefix_armed)
  );

  card_ident_pwrup #(
    .PWRUP_CYCLES (PWRUP_CYCLES)
  ) u_pwrup (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (pwr_busy)
  );

  card_ident_rca_gen #(
    .RCA_SEED (RCA_SEED),
    .RCA_MUL  (RCA_MUL),
    .RCA_INC  (RCA_INC)
  ) u_rca (
    .clk     (clk),
    .rst_n   (rst_n),
    .publish (ev_rca),
    .rca_new (rca_new),
    .rca_cur (rca_cur)
  );

  // command classification
  always_comb begin
    plain_cmd   = cmd_valid && !cmd_app;
    app_cmd     = cmd_valid && cmd_app;
    alive       = (state_q != CS_INACTIVE);
    prefix_addr = (state_q == CS_STBY) ? rca_cur : 16'h0000;

    ev_prefix_ok  = plain_cmd && alive && (cmd_index == IDX_PREFIX)
                    && (cmd_arg[31:16] == prefix_addr);
    ev_opcond     = app_cmd && (cmd_index == IDX_OPCOND) && prefix_armed
                    && (state_q == CS_IDLE);
    ev_opcond_ok  = ev_opcond && window_fits(cmd_arg[23:0], OCR_WINDOW);
    ev_opcond_bad = ev_opcond && !window_fits(cmd_arg[23:0], OCR_WINDOW);
    ev_cid        = plain_cmd && (cmd_index == IDX_IDENT) && (state_q == CS_READY);
    ev_rca        = plain_cmd && (cmd_index == IDX_ADDR)
                    && ((state_q == CS_IDENT) || (state_q == CS_STBY));
    ev_answer     = ev_prefix_ok || ev_opcond_ok || ev_cid || ev_rca;
    ev_invalid    = cmd_valid && !ev_answer && !ev_opcond_bad;
  end

  // next state and response payload
  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    data_d  = data_q;
    if (ev_prefix_ok) begin
      kind_d = RK_ACK;
      data_d = {125'h0, state_q};
    end else if (ev_opcond_bad) begin
      state_d = CS_INACTIVE;
    end else if (ev_opcond_ok) begin
      kind_d = RK_OCR;
      data_d = {96'h0, ocr_word(!pwr_busy, OCR_WINDOW)};
      if (!pwr_busy) state_d = CS_READY;
    end else if (ev_cid) begin
      kind_d  = RK_IDENT;
      data_d  = CID_VALUE;
      state_d = CS_IDENT;
    end else if (ev_rca) begin
      kind_d  = RK_ADDR;
      data_d  = {96'h0, rca_new, 16'h0000};
      state_d = CS_STBY;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= CS_IDLE;
      kind_q  <= RK_ACK;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      data_q  <= data_d;
      valid_q <= ev_answer;
    end
  end

  assign rsp_valid  = valid_q;
  assign rsp_kind   = kind_q;
  assign rsp_data   = data_q;
  assign card_state = state_q;
  assign rca_out    = rca_cur;

endmodule

// File: rtl/card_ident_chk.sv
module card_ident_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         cmd_valid,
  input logic         rsp_valid,
  input logic [1:0]   rsp_kind,
  input logic [127:0] rsp_data,
  input logic [2:0]   card_state,
  input logic [15:0]  rca_out,
  input logic         prefix_armed,
  input logic         ev_invalid
);

  a_r5_inactive_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    card_state == 3'd7 |=> card_state == 3'd7);

  a_r5_inactive_silent: assert property (@(posedge clk) disable iff (!rst_n)
    card_state == 3'd7 |=> !rsp_valid);

  a_r8_rca_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_kind == 2'd3 |-> rsp_data[31:16] != 16'h0 && rsp_data[31:16] == rca_out);

  a_r10_rsp_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(cmd_valid));

  a_r3_opcond_needs_prefix: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_kind == 2'd1 |-> $past(prefix_armed) && $past(card_state) == 3'd0);

  a_r6_ident_from_ready: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_kind == 2'd2 |-> $past(card_state) == 3'd1 && card_state == 3'd2);

  a_r2_prefix_acked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prefix_armed) |-> rsp_valid && rsp_kind == 2'd0);

  a_r9_invalid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ev_invalid |=> !rsp_valid && $stable(card_state) && $stable(rca_out));

  a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(card_state));

endmodule

bind card_ident_ctrl card_ident_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_valid    (cmd_valid),
  .rsp_valid    (rsp_valid),
  .rsp_kind     (rsp_kind),
  .rsp_data     (rsp_data),
  .card_state   (card_state),
  .rca_out      (rca_out),
  .prefix_armed (prefix_armed),
  .ev_invalid   (ev_invalid)
);

// File: tb/test_card_ident_ctrl.sv
`timescale 1ns/1ps
module test_card_ident_ctrl;

  localparam logic [127:0] CID = 128'h0312_5A3C_9E71_0B44_2D68_F0C1_5577_A9E3;
  localparam logic [23:0]  WIN = 24'hFF8000;
  localparam int           PWR = 64;
  localparam logic [15:0]  INC = 16'hFFFB;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic [5:0]   cmd_index = '0;
  logic [31:0]  cmd_arg = '0;
  logic         cmd_app = 1'b0;
  logic         rsp_valid;
  logic [1:0]   rsp_kind;
  logic [127:0] rsp_data;
  logic [2:0]   card_state;
  logic [15:0]  rca_out;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  // reference model
  logic [2:0]  m_state;
  logic        m_prefix;
  logic [15:0] m_rca, m_gen;

  always #2.5 clk = ~clk;

  card_ident_ctrl i_card_ident_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_index(cmd_index),
    .cmd_arg(cmd_arg), .cmd_app(cmd_app), .rsp_valid(rsp_valid),
    .rsp_kind(rsp_kind), .rsp_data(rsp_data), .card_state(card_state),
    .rca_out(rca_out)
  );

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else if (cyc < PWR) cyc <= cyc + 1;
  end

  function automatic logic [15:0] b_step(input logic [15:0] x);
    logic [15:0] y;
    y = (x << 2) + x + INC;
    if (y == 16'h0) y = (y << 2) + y + INC;
    return y;
  endfunction

  task automatic check(input logic ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_state = 3'd0; m_prefix = 1'b0; m_rca = 16'h0; m_gen = 16'h0001;
    @(negedge clk);
  endtask

  task automatic issue(input logic [5:0] idx, input logic [31:0] arg,
                       input logic app, input string req);
    logic        ev;
    logic [1:0]  ek;
    logic [127:0] ed;
    logic [2:0]  ns;
    logic        np;
    ev = 1'b0; ek = 2'd0; ed = '0; ns = m_state; np = 1'b0;
    cmd_index = idx; cmd_arg = arg; cmd_app = app; cmd_valid = 1'b1;
    if (m_state != 3'd7) begin
      if (!app && idx == 6'd55 && arg[31:16] == ((m_state == 3'd3) ? m_rca : 16'h0)) begin
        ev = 1'b1; ek = 2'd0; ed = {125'h0, m_state}; np = 1'b1;
      end else if (app && idx == 6'd41 && m_prefix && m_state == 3'd0) begin
        if ((arg[23:0] & WIN) == 24'h0) ns = 3'd7;
        else begin
          ev = 1'b1; ek = 2'd1;
          ed = {96'h0, (cyc >= PWR), 7'b0, WIN};
          if (cyc >= PWR) ns = 3'd1;
        end
      end else if (!app && idx == 6'd2 && m_state == 3'd1) begin
        ev = 1'b1; ek = 2'd2; ed = CID; ns = 3'd2;
      end else if (!app && idx == 6'd3 && (m_state == 3'd2 || m_state == 3'd3)) begin
        m_gen = b_step(m_gen); m_rca = m_gen;
        ev = 1'b1; ek = 2'd3; ed = {96'h0, m_rca, 16'h0}; ns = 3'd3;
      end
    end
    m_state = ns; m_prefix = np;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(rsp_valid == ev, req, {127'h0, rsp_valid}, {127'h0, ev});
    if (ev) begin
      check(rsp_kind == ek, req, {126'h0, rsp_kind}, {126'h0, ek});
      check(rsp_data == ed, req, rsp_data, ed);
    end
    check(card_state == m_state, req, {125'h0, card_state}, {125'h0, m_state});
    check(rca_out == m_rca, req, {112'h0, rca_out}, {112'h0, m_rca});
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset();
    // R1 reset state
    check(card_state == 3'd0, "R1", {125'h0, card_state}, 128'h0);
    check(rsp_valid == 1'b0, "R1", {127'h0, rsp_valid}, 128'h0);
    check(rca_out == 16'h0, "R1", {112'h0, rca_out}, 128'h0);

    issue(6'd41, {8'h0, WIN}, 1'b1, "R3 query without prefix");
    issue(6'd2, 32'h0, 1'b0, "R9 identifier in Idle");
    issue(6'd55, 32'h1234_0000, 1'b0, "R2 prefix with wrong address");
    issue(6'd55, 32'h0, 1'b0, "R2 prefix accepted");
    issue(6'd2, 32'h0, 1'b0, "R2 prefix consumed by other command");
    issue(6'd41, {8'h0, WIN}, 1'b1, "R2 prefix one-shot");
    issue(6'd55, 32'h0, 1'b0, "R2 prefix");
    issue(6'd41, 32'h0030_0000, 1'b1, "R4 query while busy");
    check(card_state == 3'd0, "R4 busy stays Idle", {125'h0, card_state}, 128'h0);
    repeat (PWR + 10) @(negedge clk);
    issue(6'd55, 32'h0, 1'b0, "R2 prefix");
    issue(6'd41, 32'h0030_0000, 1'b1, "R4 query ready");
    check(card_state == 3'd1, "R4 Ready", {125'h0, card_state}, 128'h1);
    // R10 pulse lasts one cycle
    @(negedge clk);
    check(rsp_valid == 1'b0, "R10 one-cycle pulse", {127'h0, rsp_valid}, 128'h0);
    issue(6'd3, 32'h0, 1'b0, "R9 address in Ready");
    issue(6'd2, 32'h0, 1'b1, "R9 identifier flagged as app");
    issue(6'd2, 32'h0, 1'b0, "R6 identifier");
    issue(6'd2, 32'h0, 1'b0, "R6 identifier repeated in Ident");
    issue(6'd3, 32'h0, 1'b0, "R7 first address");
    check(rca_out == 16'hFFFB, "R8 zero skipped", {112'h0, rca_out}, 128'hFFFB);
    issue(6'd3, 32'h0, 1'b0, "R7 republish");
    check(rca_out == 16'hFFE2, "R8 second address", {112'h0, rca_out}, 128'hFFE2);
    issue(6'd55, 32'h0, 1'b0, "R2 zero address in Stand-by");
    issue(6'd55, {m_rca, 16'h0}, 1'b0, "R2 own address in Stand-by");
    issue(6'd41, {8'h0, WIN}, 1'b1, "R3 query outside Idle");

    // random phase
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r, a;
      r = $urandom % 8;
      a = $urandom;
      case (r)
        0: issue(6'd55, {m_rca, a[15:0]}, 1'b0, "R2 random prefix");
        1: issue(6'd55, a, 1'b0, "R2 random prefix arg");
        2: issue(6'd41, a, 1'b1, "R3 random query");
        3: issue(6'd2, a, 1'b0, "R6 random identifier");
        4: issue(6'd3, a, 1'b0, "R7 random address");
        5: issue(6'(a[5:0]), a, a[6], "R9 random command");
        6: issue(6'd3, a, 1'b1, "R9 app-flagged address");
        default: begin
          repeat (a[2:0]) @(negedge clk);
          issue(6'd55, {m_rca, 16'h0}, 1'b0, "R2 random gap");
        end
      endcase
    end

    // R5 incompatible window
    do_reset();
    issue(6'd55, 32'h0, 1'b0, "R2 prefix");
    issue(6'd41, 32'h0000_0080, 1'b1, "R5 mismatch");
    check(card_state == 3'd7, "R5 Inactive", {125'h0, card_state}, 128'h7);
    issue(6'd55, 32'h0, 1'b0, "R5 prefix ignored");
    issue(6'd41, {8'h0, WIN}, 1'b1, "R5 query ignored");
    issue(6'd2, 32'h0, 1'b0, "R5 identifier ignored");
    issue(6'd3, 32'h0, 1'b0, "R5 address ignored");
    summary();
  end

endmodule